// File: doc/BRIEF.md
# Programmable Periodic-Rate and Square-Wave Divider

This block divides a 32.768 kHz timebase through a 15-stage binary chain. A 4-bit rate code picks one of 13 stages. The chosen stage does two things. It produces a single-cycle periodic event pulse once per stage period, and it feeds a square-wave output that is gated by an enable bit and by a power-fail inhibit. The timebase arrives as a one-cycle `tick` strobe in the system clock domain, so the whole block runs on one clock. A synchronous `div_rst` input clears the chain.

The square-wave path is a three-state machine: `ST_OFF`, `ST_ALIGN` and `ST_RUN`.
- From any state, the machine goes to `ST_OFF` when the gate closes. The gate closes when the enable is low, the inhibit is high, or the code is 0.
- With the gate open, `ST_OFF` moves to `ST_ALIGN`.
- `ST_ALIGN` moves to `ST_RUN` on the first event of the selected stage.
- A divider reset, or a code that differs from the previous cycle's code, sends `ST_ALIGN` or `ST_RUN` back to `ST_ALIGN`.

The output is low in every state except `ST_RUN`. In `ST_RUN` it is high for the first half of each period.

Top module: `rtc_rate_divider`

## Requirements
- R1: On every cycle with `tick` high and `div_rst` low, the 15-bit chain advances by one and wraps from 32767 to 0. The event spacing of a stage stays constant across the wrap and scales with the tick rate.
- R2: Code 0 gives no event pulse and keeps `sq_out` low.
- R3: A code c from 3 to 15 selects an event period of 2^(c-1) ticks. Code 3 gives 4 ticks (8.192 kHz) and code 15 gives 16384 ticks (2 Hz).
- R4: Codes 1 and 2 behave exactly like codes 8 and 9, with periods of 128 and 256 ticks.
- R5: `per_pulse` is high for exactly one cycle, in the cycle after the tick that completes a period of the selected stage. A period is complete when the chain value modulo the period equals the period minus one.
- R6: While `sq_en` is low, `sq_out` is low in the following cycle. After the gate opens, `sq_out` stays low until the next event. From then on it is high for the first half of each period, and it rises only together with `per_pulse`.
- R7: While `pf_inhibit` is high, `sq_out` is low in the following cycle. Events continue while the inhibit is active.
- R8: While `div_rst` is high, the chain holds at zero and no events occur. The first event after release comes one full period (2^(c-1) ticks) later, and `sq_out` stays low until that event.
- R9: A cycle whose code differs from the previous cycle's code forces `sq_out` low from the next cycle. The output stays low until the first event of the new stage.
- R10: While `rst_n` is low, `sq_out` and `per_pulse` are low and the chain is at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at the 32.768 kHz timebase rate |
| div_rst | input | 1 | Synchronous divider clear, active high |
| rate_sel | input | 4 | Rate code; 0 turns both outputs off |
| sq_en | input | 1 | Square-wave enable |
| pf_inhibit | input | 1 | Power-fail inhibit; forces the square wave low |
| sq_out | output | 1 | Gated square-wave output |
| per_pulse | output | 1 | Single-cycle periodic event |

## Verification
Event spacing is measured for several direct codes, including the fastest and the slowest, and this separates a correct stage mapping from an off-by-one choice of stage. The two aliased codes are compared with their direct twins, and a sparse tick pattern shows that the spacing follows ticks rather than clock cycles. The enable, the inhibit, code 0, a mid-run code change and a divider-reset release each probe a different path into the gating machine. Throughout, a behavioural model computes the expected event and the expected square-wave level from modular arithmetic on a tick count, and the bench compares both against the outputs every cycle.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } sq_state_e;

    // codes at or below ALIAS_LAST reuse the stages of code + ALIAS_SHIFT
    localparam int ALIAS_LAST  = 2;
    localparam int ALIAS_SHIFT = 7;
    localparam int TAP_OFFSET  = 2;

    function automatic int code_stage(input int code);
        if (code <= ALIAS_LAST)
            return code + ALIAS_SHIFT - TAP_OFFSET;
        return code - TAP_OFFSET;
    endfunction

endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              div_rst,
    output logic [STAGES-1:0] cnt_next,
    output logic [STAGES-1:0] wrap_ev
);

    logic [STAGES-1:0] cnt_q;

    always_comb begin
        if (div_rst)
            cnt_next = '0;
        else if (tick)
            cnt_next = cnt_q + STAGES'(1);
        else
            cnt_next = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

    // stage b completes a period when its low b+1 bits are all ones on a tick
    for (genvar b = 0; b < STAGES; b++) begin : g_wrap
        assign wrap_ev[b] = tick & ~div_rst & (&cnt_q[b:0]);
    end

endmodule

// File: rtl/rtc_tap_mux.sv
module rtc_tap_mux #(
    parameter int STAGES = 15,
    parameter int SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic [STAGES-1:0] cnt_next,
    input  logic [STAGES-1:0] wrap_ev,
    output logic              tap_on,
    output logic              tap_ev,
    output logic              tap_lvl
);
    import rtc_div_pkg::*;

    int stage;

    always_comb begin
        stage  = code_stage(int'(rate_sel));
        tap_on = (rate_sel != '0) && (stage < STAGES);
        tap_ev  = 1'b0;
        tap_lvl = 1'b0;
        for (int i = 0; i < STAGES; i++) begin
            if (tap_on && stage == i) begin
                tap_ev  = wrap_ev[i];
                tap_lvl = ~cnt_next[i];
            end
        end
    end

endmodule

// File: rtl/rtc_sq_fsm.sv
module rtc_sq_fsm #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             sq_en,
    input  logic             pf_inhibit,
    input  logic             div_rst,
    input  logic             tap_on,
    input  logic             tap_ev,
    input  logic             tap_lvl,
    output logic             sq_out
);
    import rtc_div_pkg::*;

    sq_state_e        st, nxt;
    logic [SEL_W-1:0] sel_q;
    logic             gate_ok, restart;

    assign gate_ok = sq_en & ~pf_inhibit & tap_on;
    assign restart = div_rst | (rate_sel != sel_q);

    always_comb begin
        nxt = st;
        if (!gate_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:   nxt = ST_ALIGN;
                ST_ALIGN: nxt = restart ? ST_ALIGN : (tap_ev ? ST_RUN : ST_ALIGN);
                ST_RUN:   nxt = restart ? ST_ALIGN : ST_RUN;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_OFF;
            sel_q <= '0;
        end else begin
            st    <= nxt;
            sel_q <= rate_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sq_out <= 1'b0;
        else
            sq_out <= (nxt == ST_RUN) & tap_lvl;
    end

    // R6: the running state is reachable only with the enable seen the cycle before
    p_run_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> $past(sq_en));

    // R9: a rate change never lets the output rise in the following cycle
    p_change_realigns_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != sel_q) |=> (st != ST_RUN));

endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider #(
    parameter int STAGES = 15,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             div_rst,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             sq_en,
    input  logic             pf_inhibit,
    output logic             sq_out,
    output logic             per_pulse
);

    logic [STAGES-1:0] cnt_next, wrap_ev;
    logic              tap_on, tap_ev, tap_lvl;

    rtc_div_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .div_rst  (div_rst),
        .cnt_next (cnt_next),
        .wrap_ev  (wrap_ev)
    );

    rtc_tap_mux #(.STAGES(STAGES), .SEL_W(SEL_W)) u_mux (
        .rate_sel (rate_sel),
        .cnt_next (cnt_next),
        .wrap_ev  (wrap_ev),
        .tap_on   (tap_on),
        .tap_ev   (tap_ev),
        .tap_lvl  (tap_lvl)
    );

    rtc_sq_fsm #(.SEL_W(SEL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .sq_en      (sq_en),
        .pf_inhibit (pf_inhibit),
        .div_rst    (div_rst),
        .tap_on     (tap_on),
        .tap_ev     (tap_ev),
        .tap_lvl    (tap_lvl),
        .sq_out     (sq_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            per_pulse <= 1'b0;
        else
            per_pulse <= tap_ev;
    end

    p_zero_code_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '0) |=> (!per_pulse && !sq_out));

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        per_pulse |=> !per_pulse);

    p_disabled_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |=> !sq_out);

    p_rise_with_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sq_out) |-> per_pulse);

    p_inhibit_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_inhibit |=> !sq_out);

    p_divrst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |=> (!per_pulse && !sq_out));

    p_sel_change_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != $past(rate_sel)) |=> !sq_out);

endmodule

// File: tb/sim_rtc_rate_divider.sv
module sim_rtc_rate_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       div_rst = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       sq_en = 1'b0;
    logic       pf_inhibit = 1'b0;
    logic       sq_out, per_pulse;

    int checks = 0;
    int failures = 0;
    int tick_every = 1;

    // reference model state
    int m_cnt = 0;
    int m_st = 0;
    int m_sel_prev = 0;
    bit exp_sq = 1'b0;
    bit exp_pulse = 1'b0;

    always #4 clk = ~clk;

    rtc_rate_divider u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .div_rst    (div_rst),
        .rate_sel   (rate_sel),
        .sq_en      (sq_en),
        .pf_inhibit (pf_inhibit),
        .sq_out     (sq_out),
        .per_pulse  (per_pulse)
    );

    function automatic int period_of(input int code);
        if (code == 0) return 0;
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // behavioural reference, evaluated on the values held since the previous falling edge
    always @(posedge clk) begin
        int p;
        bit ev, ok;
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_sel_prev = 0; exp_sq = 0; exp_pulse = 0;
        end else begin
            p  = period_of(int'(rate_sel));
            ev = (p > 0) && tick && !div_rst && ((m_cnt % p) == p - 1);
            ok = sq_en && !pf_inhibit && (p > 0);
            if (!ok) m_st = 0;
            else if (div_rst || int'(rate_sel) != m_sel_prev || m_st == 0) m_st = 1;
            else if (m_st == 1 && ev) m_st = 2;
            if (div_rst) m_cnt = 0;
            else if (tick) m_cnt = (m_cnt + 1) % 32768;
            exp_pulse  = ev;
            exp_sq     = (m_st == 2) && ((m_cnt % p) < p / 2);
            m_sel_prev = int'(rate_sel);
        end
    end

    // timebase strobe
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc++;
            tick = ((tc % tick_every) == 0);
        end
    end

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(per_pulse == exp_pulse, "R5 event pulse vs model", per_pulse, exp_pulse);
                chk(sq_out == exp_sq, "R6 square wave vs model", sq_out, exp_sq);
            end
        end
    end

    task automatic interval(output int n);
        do @(negedge clk); while (!per_pulse);
        n = 0;
        do begin @(negedge clk); n++; end while (!per_pulse);
    endtask

    task automatic count_for(input int cyc, output int pulses, output int highs);
        pulses = 0; highs = 0;
        repeat (cyc) begin
            @(negedge clk);
            pulses += per_pulse;
            highs  += sq_out;
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, pulses, highs;
        repeat (4) @(negedge clk);
        // R10: reset state
        chk(sq_out == 0, "R10 sq_out in reset", sq_out, 0);
        chk(per_pulse == 0, "R10 per_pulse in reset", per_pulse, 0);
        rst_n = 1'b1;

        // R3: fastest direct code
        rate_sel = 4'd3; sq_en = 1'b1;
        interval(n); chk(n == 4, "R3 code 3 spacing", n, 4);
        count_for(8, pulses, highs);
        chk(highs == 4, "R6 code 3 duty", highs, 4);
        rate_sel = 4'd5;
        interval(n); chk(n == 16, "R3 code 5 spacing", n, 16);

        // R4: aliased codes match their twins
        rate_sel = 4'd1;
        interval(n); chk(n == 128, "R4 code 1 spacing", n, 128);
        rate_sel = 4'd8;
        interval(n); chk(n == 128, "R4 code 8 spacing", n, 128);
        rate_sel = 4'd2;
        interval(n); chk(n == 256, "R4 code 2 spacing", n, 256);

        // R2: code 0 silences both outputs
        rate_sel = 4'd0;
        count_for(600, pulses, highs);
        chk(pulses == 0, "R2 no events on code 0", pulses, 0);
        chk(highs == 0, "R2 no square wave on code 0", highs, 0);

        // R7: inhibit keeps output low but events continue
        rate_sel = 4'd4; pf_inhibit = 1'b1;
        count_for(300, pulses, highs);
        chk(highs == 0, "R7 square wave under inhibit", highs, 0);
        chk(pulses > 0, "R7 events under inhibit", pulses, 37);
        pf_inhibit = 1'b0;

        // R6: enable low keeps output low
        sq_en = 1'b0;
        count_for(200, pulses, highs);
        chk(highs == 0, "R6 square wave while disabled", highs, 0);
        sq_en = 1'b1;

        // R8: divider reset then release with code 6 (32 ticks)
        rate_sel = 4'd6; div_rst = 1'b1;
        count_for(10, pulses, highs);
        chk(pulses == 0, "R8 no events in divider reset", pulses, 0);
        div_rst = 1'b0;
        n = 0; highs = 0;
        do begin @(negedge clk); n++; if (!per_pulse) highs += sq_out; end while (!per_pulse);
        chk(n == 32, "R8 first event after release", n, 32);
        chk(highs == 0, "R8 output low before first event", highs, 0);
        chk(sq_out == 1, "R8 output rises with first event", sq_out, 1);

        // R9: code change while running
        @(negedge clk);
        rate_sel = 4'd7;
        @(negedge clk);
        chk(sq_out == 0, "R9 output low after change", sq_out, 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!sq_out);
        chk(per_pulse == 1, "R9 output resumes on new event", per_pulse, 1);

        // R1: sparse ticks, one every three cycles
        tick_every = 3; rate_sel = 4'd3;
        interval(n); chk(n == 12, "R1 spacing follows ticks", n, 12);
        tick_every = 1;

        // R1/R3: slowest code across a chain wrap
        rate_sel = 4'd15;
        interval(n); chk(n == 16384, "R3 code 15 spacing", n, 16384);
        interval(n); chk(n == 16384, "R1 spacing across wrap", n, 16384);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule